// File: doc/BRIEF.md
# Interrupt-Queued Package Merger

This block joins the output of three compression channels into one byte stream. A channel raises its interrupt line once it holds a complete package of fixed length. The merger records each such event in a small queue. It then serves the requests strictly in the order they arrived. For each request it first emits a four-byte header and then pulls the package bytes from the chosen channel through a read-request / valid handshake.

The header identifies where a package came from and where it sits in that source's sequence, so a downstream reassembler can route and order the packages. A channel may stall at any point during its package; the merger counts accepted bytes, not cycles. The queue is lossy on overflow: an arrival that finds no free slot is dropped and a sticky error flag is raised.

Top module: `pkg_merger`

## Requirements
- R1: An interrupt is taken on its rising edge only. A line held high adds no further entries.
- R2: Queued requests are served oldest first, whatever the channel index.
- R3: When several interrupt lines rise in the same cycle, their entries are queued in ascending channel index (channel 0 first).
- R4: Every package is preceded by exactly four header bytes, with out_hdr_o high on those bytes only: byte 0 is 0xA5, byte 1 is the channel index (0, 1 or 2), bytes 2 and 3 are that channel's 16-bit sequence number, high byte first.
- R5: Each channel has its own sequence number. It is 0 after reset and increases by one after each package from that channel.
- R6: rd_req_o has at most one bit set, and only for the channel being drawn. Valid strobes on any channel whose request is low are ignored.
- R7: Exactly PKG_BYTES bytes, taken on cycles where the selected channel's valid is high, are forwarded after the header in arrival order. Gaps in valid are tolerated. After the last byte the request is removed from the queue.
- R8: The queue holds Q_DEPTH (default 8) entries, including the one in service. A slot freed by a removal in the same cycle may be reused. An arrival with no free slot is discarded and sets q_err_o, which stays high until reset.
- R9: After reset all outputs are low. out_valid_o is high only when the queue held an entry in the previous cycle, so the output stays silent while nothing is queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | NUM_CH | Package-ready interrupt, one per channel |
| ch_valid_i | input | NUM_CH | Byte-valid strobe, one per channel |
| ch_data_i | input | NUM_CH*8 | Channel bytes; channel k is at bits [8k+7:8k] |
| rd_req_o | output | NUM_CH | Read request to the channel being drawn |
| out_valid_o | output | 1 | Merged stream byte valid |
| out_data_o | output | 8 | Merged stream byte |
| out_hdr_o | output | 1 | Marks header bytes of the merged stream |
| q_err_o | output | 1 | Sticky queue-overflow flag |

## Verification
Interrupts are raised one at a time in non-index order, which shows that the service order follows arrival and not priority. They are also raised together in groups, which shows the ascending tie-break. Data is drawn with continuous valid and with periodic gaps, so byte counting is tested against cycle counting. A level held high and junk strobes on idle channels test that only edges enqueue and that only the selected channel feeds the stream. With all channels stalled, nine edges fill and then overflow the queue, which tests the discard and the sticky flag. A final reset shows the sequence numbers and the flag cleared.

// File: rtl/merger_pkg.sv
package merger_pkg;
  localparam int BYTE_W    = 8;
  localparam int HDR_BYTES = 4;
  localparam int SEQ_W     = 16;
  localparam logic [BYTE_W-1:0] SYNC_BYTE = 8'hA5;

  typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_DATA} draw_st_e;

  function automatic logic [BYTE_W-1:0] hdr_byte(input logic [1:0]       idx,
                                                 input logic [BYTE_W-1:0] ch,
                                                 input logic [SEQ_W-1:0]  seq);
    case (idx)
      2'd0:    return SYNC_BYTE;
      2'd1:    return ch;
      2'd2:    return seq[15:8];
      default: return seq[7:0];
    endcase
  endfunction
endpackage

// File: rtl/pm_edge_detect.sv
module pm_edge_detect #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= '0;
    else         lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/pm_irq_fifo.sv
module pm_irq_fifo #(
  parameter int NUM_CH = 3,
  parameter int DEPTH  = 8,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] push_i,
  input  logic              pop_i,
  output logic              empty_o,
  output logic [CH_W-1:0]   head_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              err_o
);
  logic [CH_W-1:0]  mem_q [DEPTH];
  logic [CNT_W-1:0] count_q;
  int unsigned      rd_ptr_q;
  logic             err_q;

  logic [NUM_CH-1:0] accept;
  int unsigned       slot [NUM_CH];
  int unsigned       n_acc;
  logic              drop;

  // pop frees its slot first; pushes fill the free space in ascending channel order
  always_comb begin
    int unsigned free;
    free  = DEPTH - int'(count_q) + (pop_i ? 1 : 0);
    n_acc = 0;
    drop  = 1'b0;
    for (int c = 0; c < NUM_CH; c++) begin
      accept[c] = 1'b0;
      slot[c]   = 0;
      if (push_i[c]) begin
        if (n_acc < free) begin
          accept[c] = 1'b1;
          slot[c]   = (rd_ptr_q + int'(count_q) + n_acc) % DEPTH;
          n_acc     = n_acc + 1;
        end else begin
          drop = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr_q <= 0;
      count_q  <= '0;
      err_q    <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (pop_i) rd_ptr_q <= (rd_ptr_q + 1) % DEPTH;
      count_q <= CNT_W'(int'(count_q) - (pop_i ? 1 : 0) + int'(n_acc));
      if (drop) err_q <= 1'b1;
      for (int c = 0; c < NUM_CH; c++)
        if (accept[c]) mem_q[slot[c]] <= CH_W'(c);
    end
  end

  assign empty_o = (count_q == '0);
  assign head_o  = mem_q[rd_ptr_q];
  assign count_o = count_q;
  assign err_o   = err_q;
endmodule

// File: rtl/pm_draw_engine.sv
module pm_draw_engine
  import merger_pkg::*;
#(
  parameter int NUM_CH    = 3,
  parameter int PKG_BYTES = 256,
  localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int BCNT_W   = $clog2(PKG_BYTES + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     q_empty_i,
  input  logic [CH_W-1:0]          q_head_i,
  input  logic [NUM_CH-1:0]        ch_valid_i,
  input  logic [NUM_CH*BYTE_W-1:0] ch_data_i,
  output logic [NUM_CH-1:0]        rd_req_o,
  output logic                     pop_o,
  output logic                     out_valid_o,
  output logic [BYTE_W-1:0]        out_data_o,
  output logic                     out_hdr_o
);
  draw_st_e          state_q;
  logic [CH_W-1:0]   sel_q;
  logic [1:0]        hidx_q;
  logic [BCNT_W-1:0] bcnt_q;
  logic [SEQ_W-1:0]  seq_q [NUM_CH];

  logic              take, last;
  logic [BYTE_W-1:0] cur_byte;

  assign take     = (state_q == ST_DATA) && ch_valid_i[sel_q];
  assign last     = take && (bcnt_q == BCNT_W'(PKG_BYTES - 1));
  assign pop_o    = last;
  assign cur_byte = ch_data_i[int'(sel_q)*BYTE_W +: BYTE_W];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_req
    assign rd_req_o[g] = (state_q == ST_DATA) && (sel_q == CH_W'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      sel_q       <= '0;
      hidx_q      <= '0;
      bcnt_q      <= '0;
      out_valid_o <= 1'b0;
      out_hdr_o   <= 1'b0;
      out_data_o  <= '0;
      for (int c = 0; c < NUM_CH; c++) seq_q[c] <= '0;
    end else begin
      out_valid_o <= 1'b0;
      out_hdr_o   <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (!q_empty_i) begin
            sel_q   <= q_head_i;
            hidx_q  <= '0;
            state_q <= ST_HDR;
          end
        end
        ST_HDR: begin
          out_valid_o <= 1'b1;
          out_hdr_o   <= 1'b1;
          out_data_o  <= hdr_byte(hidx_q, BYTE_W'(sel_q), seq_q[sel_q]);
          hidx_q      <= hidx_q + 2'd1;
          if (hidx_q == 2'(HDR_BYTES - 1)) begin
            bcnt_q  <= '0;
            state_q <= ST_DATA;
          end
        end
        ST_DATA: begin
          if (take) begin
            out_valid_o <= 1'b1;
            out_data_o  <= cur_byte;
            bcnt_q      <= bcnt_q + 1'b1;
          end
          if (last) begin
            seq_q[sel_q] <= seq_q[sel_q] + 1'b1;
            state_q      <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pkg_merger.sv
module pkg_merger
  import merger_pkg::*;
#(
  parameter int NUM_CH    = 3,
  parameter int PKG_BYTES = 256,
  parameter int Q_DEPTH   = 8,
  localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int CNT_W    = $clog2(Q_DEPTH + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_CH-1:0]        irq_i,
  input  logic [NUM_CH-1:0]        ch_valid_i,
  input  logic [NUM_CH*BYTE_W-1:0] ch_data_i,
  output logic [NUM_CH-1:0]        rd_req_o,
  output logic                     out_valid_o,
  output logic [BYTE_W-1:0]        out_data_o,
  output logic                     out_hdr_o,
  output logic                     q_err_o
);
  logic [NUM_CH-1:0] irq_rise;
  logic              q_empty, q_pop;
  logic [CH_W-1:0]   q_head;
  logic [CNT_W-1:0]  q_count;

  pm_edge_detect #(.N(NUM_CH)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (irq_i),
    .rise_o (irq_rise)
  );

  pm_irq_fifo #(.NUM_CH(NUM_CH), .DEPTH(Q_DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (irq_rise),
    .pop_i   (q_pop),
    .empty_o (q_empty),
    .head_o  (q_head),
    .count_o (q_count),
    .err_o   (q_err_o)
  );

  pm_draw_engine #(.NUM_CH(NUM_CH), .PKG_BYTES(PKG_BYTES)) u_draw (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .q_empty_i   (q_empty),
    .q_head_i    (q_head),
    .ch_valid_i  (ch_valid_i),
    .ch_data_i   (ch_data_i),
    .rd_req_o    (rd_req_o),
    .pop_o       (q_pop),
    .out_valid_o (out_valid_o),
    .out_data_o  (out_data_o),
    .out_hdr_o   (out_hdr_o)
  );
endmodule

// File: rtl/pkg_merger_checker.sv
module pkg_merger_checker
  import merger_pkg::*;
#(
  parameter int NUM_CH  = 3,
  parameter int Q_DEPTH = 8,
  parameter int CH_W    = 2,
  parameter int CNT_W   = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NUM_CH-1:0] rd_req_o,
  input logic              out_valid_o,
  input logic [BYTE_W-1:0] out_data_o,
  input logic              out_hdr_o,
  input logic              q_err_o,
  input logic              q_empty,
  input logic              q_pop,
  input logic [CH_W-1:0]   q_head,
  input logic [CNT_W-1:0]  q_count
);
  assert_req_onehot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rd_req_o));

  assert_req_is_head_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rd_req_o) |-> rd_req_o[q_head]);

  assert_hdr_sync_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_hdr_o) |-> (out_data_o == SYNC_BYTE));

  assert_hdr_is_valid_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_hdr_o |-> out_valid_o);

  assert_pop_nonempty_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_pop |-> !q_empty);

  assert_no_overflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(q_count) <= Q_DEPTH);

  assert_err_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_err_o |=> q_err_o);

  assert_valid_needs_entry_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(!q_empty));
endmodule

bind pkg_merger pkg_merger_checker #(
  .NUM_CH(NUM_CH), .Q_DEPTH(Q_DEPTH), .CH_W(CH_W), .CNT_W(CNT_W)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rd_req_o    (rd_req_o),
  .out_valid_o (out_valid_o),
  .out_data_o  (out_data_o),
  .out_hdr_o   (out_hdr_o),
  .q_err_o     (q_err_o),
  .q_empty     (q_empty),
  .q_pop       (q_pop),
  .q_head      (q_head),
  .q_count     (q_count)
);

// File: tb/pkg_merger_tb_top.sv
module pkg_merger_tb_top;
  localparam int NCH = 3;
  localparam int PKG = 16;
  localparam int QD  = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NCH-1:0]   irq = '0;
  logic [NCH-1:0]   ch_valid = '0;
  logic [NCH*8-1:0] ch_data = '0;
  logic [NCH-1:0]   rd_req;
  logic             out_valid, out_hdr, q_err;
  logic [7:0]       out_data;

  always #4 clk = ~clk;

  pkg_merger #(.NUM_CH(NCH), .PKG_BYTES(PKG), .Q_DEPTH(QD)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .ch_valid_i(ch_valid), .ch_data_i(ch_data),
    .rd_req_o(rd_req), .out_valid_o(out_valid), .out_data_o(out_data),
    .out_hdr_o(out_hdr), .q_err_o(q_err)
  );

  int checks = 0;
  int fails  = 0;
  logic [8:0] sb[$];
  int seq_exp [NCH];
  int sent [NCH];
  logic [NCH-1:0] hold = '0;
  logic [NCH-1:0] junk = '0;
  bit gaps = 0;
  int cyc = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard driver: header then package bytes for channel ch
  task automatic expect_pkg(input int ch);
    int s;
    s = seq_exp[ch];
    sb.push_back({1'b1, 8'hA5});
    sb.push_back({1'b1, 8'(ch)});
    sb.push_back({1'b1, 8'(s >> 8)});
    sb.push_back({1'b1, 8'(s)});
    for (int i = 0; i < PKG; i++) sb.push_back({1'b0, 8'(ch*85 + s*PKG + i)});
    seq_exp[ch] = s + 1;
  endtask

  task automatic pulse(input logic [NCH-1:0] m, input bit fits);
    @(negedge clk);
    irq = irq | m;
    if (fits) for (int c = 0; c < NCH; c++) if (m[c]) expect_pkg(c);
    @(negedge clk);
    irq = irq & ~m;
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    irq = '0; hold = '0; junk = '0; gaps = 0;
    sb.delete();
    for (int c = 0; c < NCH; c++) begin seq_exp[c] = 0; sent[c] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // channel model
  initial forever begin
    @(negedge clk);
    cyc++;
    for (int c = 0; c < NCH; c++) begin
      if (rd_req[c] && !hold[c] && !(gaps && (cyc % 3 == 1))) begin
        ch_valid[c] = 1'b1;
        ch_data[c*8 +: 8] = 8'(c*85 + sent[c]);
        sent[c]++;
      end else if (junk[c]) begin
        ch_valid[c] = 1'b1;
        ch_data[c*8 +: 8] = 8'hFF;
      end else begin
        ch_valid[c] = 1'b0;
      end
    end
  end

  // monitor
  initial forever begin
    @(negedge clk);
    if (rst_n && out_valid) begin
      if (sb.size() == 0) begin
        check(0, "R9 unexpected byte", int'(out_data), 0);
      end else begin
        logic [8:0] e;
        e = sb.pop_front();
        check({out_hdr, out_data} == e, e[8] ? "R4 header byte" : "R7 package byte",
              int'({out_hdr, out_data}), int'(e));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=%0h expected=%0h", cyc, 0);
    finish_run();
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin seq_exp[c] = 0; sent[c] = 0; end
    repeat (2) @(negedge clk);
    check(out_valid == 0 && rd_req == 0 && q_err == 0 && out_hdr == 0, "R9 reset outputs",
          int'({out_valid, rd_req, q_err, out_hdr}), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(out_valid == 0, "R9 silent when queue empty", int'(out_valid), 0);

    // R2: arrival order 1, 0, 2; R1: levels stay high afterwards
    @(negedge clk); irq[1] = 1'b1; expect_pkg(1);
    repeat (3) @(negedge clk); irq[0] = 1'b1; expect_pkg(0);
    repeat (2) @(negedge clk); irq[2] = 1'b1; expect_pkg(2);
    drain();
    begin
      bit seen = 0;
      repeat (20) begin @(negedge clk); if (out_valid) seen = 1; end
      check(!seen, "R1 held level does not re-enqueue", int'(seen), 0);
    end
    @(negedge clk); irq = '0;

    // R3: simultaneous rises; R7: gappy valid
    gaps = 1;
    pulse(3'b111, 1);
    drain();
    pulse(3'b110, 1);
    drain();
    gaps = 0;

    // R6: junk strobes on idle channel 2 while channel 0 is drawn
    junk[2] = 1'b1;
    pulse(3'b001, 1);
    begin
      bit bad = 0;
      while (sb.size() != 0) begin @(negedge clk); if (rd_req[2] || rd_req[1]) bad = 1; end
      check(!bad, "R6 request only to drawn channel", int'(bad), 0);
    end
    junk = '0;
    drain();
    check(seq_exp[0] == 3, "R5 sequence bookkeeping", seq_exp[0], 3);

    // R8: fill with all channels stalled, then overflow
    hold = 3'b111;
    pulse(3'b001, 1);
    pulse(3'b010, 1); pulse(3'b100, 1); pulse(3'b010, 1);
    pulse(3'b100, 1); pulse(3'b010, 1); pulse(3'b100, 1); pulse(3'b010, 1);
    check(q_err == 0, "R8 no error at full depth", int'(q_err), 0);
    pulse(3'b100, 0);
    check(q_err == 1, "R8 overflow sets error", int'(q_err), 1);
    hold = '0;
    drain();
    check(q_err == 1, "R8 error is sticky", int'(q_err), 1);
    check(out_valid == 0, "R9 silent after drain", int'(out_valid), 0);

    // R5: reset restarts sequence numbers, clears error
    do_reset();
    @(negedge clk);
    check(q_err == 0, "R8 reset clears error", int'(q_err), 0);
    pulse(3'b100, 1);
    pulse(3'b100, 1);
    drain();
    check(sb.size() == 0, "R5 restarted sequence stream complete", sb.size(), 0);

    finish_run();
  end
endmodule